// File: doc/BRIEF.md
# Serial Byte Memory Slave

This block is the serial front end of an 8K x 8 byte memory. A bus master selects it with an active-low select, clocks in a command byte, and for memory commands a two-byte address, after which data bytes stream in or out at the speed of the serial clock. Writes land in the array as soon as the last bit of a byte arrives, so the master never polls for a ready state. A write-enable latch guards both the array and a small status register.

The serial pins are brought into the system clock domain through synchronizers and sampled as edges. The data input is taken on rising serial-clock edges. The data output changes on falling edges, most significant bit first. The serial clock may idle low or high while the block is deselected (clock modes 0 and 3). An active-low hold input freezes the transfer and tri-states the output.

Command codes: 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes it. Status byte layout: bit 7, bit 3 and bit 2 are writable user bits, bit 1 shows the write-enable latch, bit 0 is always 0 (never busy), and the other bits read 0.

Top module: `spi_byte_mem`

## Requirements
- R1: After reset the write-enable latch is clear and a status read returns 0x00.
- R2: Command 0x06 sets the latch (status bit 1 reads 1) and command 0x04 clears it. Neither command takes any further bytes.
- R3: Command 0x02 with a high address byte, a low address byte and data stores the data. Command 0x03 with an address returns the stored byte, MSB first. Each output bit changes after a falling clock edge and is valid at the next rising edge.
- R4: The three most significant bits of the 16-bit address are ignored, so only 13 bits select a byte.
- R5: Within a read or write burst the address advances by one per byte and wraps from 0x1FFF to 0x0000.
- R6: While the latch is clear, data bytes for the array and for the status register are discarded and change nothing.
- R7: When select goes inactive after a write transaction that received at least one data byte, or after a status write that received its data byte, the latch is cleared. A write that ends after its address bytes leaves the latch set.
- R8: A status write stores bits 7, 3 and 2 of its data byte. A status read returns them in the same positions, with bit 0 always 0.
- R9: Transfers work the same whether the serial clock idles low (mode 0) or high (mode 3) when select falls. In mode 3 the first falling edge shifts nothing out.
- R10: Only the first byte after select falls is decoded as a command. Later bytes after a completed command, and all bytes after an unknown command, are ignored until select rises.
- R11: The output enable is low whenever select is inactive or hold is low. While hold is low, serial-clock edges are ignored and the transfer resumes where it stopped.
- R12: A byte written in one selection can be read back in the very next selection without any wait or status poll.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data from the master |
| holdN | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data to the master |
| soEn | output | 1 | Output enable for the serial data pin |

## Verification
The hardest case to reach from the pins is a pause in the middle of a read byte. Half the bits have already gone out, the clock keeps toggling during the pause, and the remaining bits must continue from the same shift position. The bench pauses with hold after four bits of a read data byte and toggles the serial clock twice while paused. It checks that the output enable stays low, then finishes the byte and compares the whole value. Address wrap is reached with a four-byte burst that starts two bytes below the top of the array, and it is read back with a burst from the same start.

// File: rtl/spi_byte_mem_pkg.sv
package spi_byte_mem_pkg;

  localparam logic [7:0] CMD_WEN  = 8'h06;
  localparam logic [7:0] CMD_WDIS = 8'h04;
  localparam logic [7:0] CMD_RSTA = 8'h05;
  localparam logic [7:0] CMD_WSTA = 8'h01;
  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_WRIT = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA,
    PH_STAT_RD,
    PH_STAT_WR,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic addrHi;
    logic addrLo;
    logic txMem;
    logic txStat;
    logic memWr;
    logic addrInc;
    logic statWr;
    logic welSet;
    logic welClr;
  } ctrl_strobe_t;

endpackage

// File: rtl/spi_byte_mem_dp.sv
module spi_byte_mem_dp
  import spi_byte_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              holdN,
  input  ctrl_strobe_t      strobe,
  output logic              so,
  output logic              soEn,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              csFall,
  output logic              csRise,
  output logic              selActive,
  output logic              welQ,
  output logic [2:0]        userBits
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int NPINS = 4;
  localparam logic [NPINS-1:0] IDLE_VEC = 4'b1100;

  logic [NPINS-1:0] rawIn;
  logic [NPINS-1:0] syncOut;
  assign rawIn = {csN, holdN, sck, si};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= {SYNC_STAGES{IDLE_VEC[g]}};
      else       stage <= {stage[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = stage[SYNC_STAGES-1];
  end

  logic csS, holdS, sckS, siS;
  assign {csS, holdS, sckS, siS} = syncOut;

  logic csD, sckD;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD  <= 1'b1;
      sckD <= 1'b0;
    end else begin
      csD  <= csS;
      sckD <= sckS;
    end
  end

  logic live, sckRise, sckFall;
  assign csFall    = csD & ~csS;
  assign csRise    = ~csD & csS;
  assign selActive = ~csD;
  assign live      = ~csS & ~csD & holdS;
  assign sckRise   = live & sckS & ~sckD;
  assign sckFall   = live & ~sckS & sckD;

  logic [2:0]        bitCnt;
  logic [6:0]        rxShift;
  logic [7:0]        txShift;
  logic              sawRise;
  logic              soQ;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] txAddr;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        statusByte;

  assign byteDone   = sckRise && (bitCnt == 3'd7);
  assign rxByte     = {rxShift, siS};
  assign txAddr     = strobe.addrLo ? {addrQ[ADDR_W-1:8], rxByte} : addrQ + 1'b1;
  assign statusByte = {userBits[2], 3'b000, userBits[1:0], welQ, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      sawRise <= 1'b0;
      soQ     <= 1'b0;
    end else if (csFall) begin
      bitCnt  <= '0;
      txShift <= '0;
      sawRise <= 1'b0;
      soQ     <= 1'b0;
    end else begin
      if (sckRise) begin
        rxShift <= rxByte[6:0];
        bitCnt  <= bitCnt + 1'b1;
        sawRise <= 1'b1;
      end
      if (sckFall && sawRise) begin
        soQ     <= txShift[7];
        txShift <= {txShift[6:0], 1'b0};
      end
      if (strobe.txMem)       txShift <= mem[txAddr];
      else if (strobe.txStat) txShift <= statusByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else begin
      if (strobe.addrHi)       addrQ[ADDR_W-1:8] <= rxByte[HI_W-1:0];
      else if (strobe.addrLo)  addrQ[7:0]        <= rxByte;
      else if (strobe.addrInc) addrQ             <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.memWr && welQ) mem[addrQ] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ     <= 1'b0;
      userBits <= '0;
    end else begin
      if (strobe.statWr && welQ) userBits <= {rxByte[7], rxByte[3:2]};
      if (strobe.welSet)      welQ <= 1'b1;
      else if (strobe.welClr) welQ <= 1'b0;
    end
  end

  assign so   = soQ;
  assign soEn = live;

endmodule

// File: rtl/spi_byte_mem_ctrl.sv
module spi_byte_mem_ctrl
  import spi_byte_mem_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteDone,
  input  logic [7:0]   rxByte,
  input  logic         csFall,
  input  logic         csRise,
  output ctrl_strobe_t strobe,
  output phase_e       phase
);

  phase_e phaseQ, phaseD;
  logic   isReadQ, isReadD;
  logic   wroteQ, wroteD;

  always_comb begin
    strobe  = '0;
    phaseD  = phaseQ;
    isReadD = isReadQ;
    wroteD  = wroteQ;
    if (csFall) begin
      phaseD = PH_CMD;
      wroteD = 1'b0;
    end else if (csRise) begin
      phaseD = PH_IDLE;
      strobe.welClr = wroteQ;
      wroteD = 1'b0;
    end else if (byteDone) begin
      unique case (phaseQ)
        PH_CMD: begin
          unique case (rxByte)
            CMD_WEN:  begin strobe.welSet = 1'b1; phaseD = PH_SKIP; end
            CMD_WDIS: begin strobe.welClr = 1'b1; phaseD = PH_SKIP; end
            CMD_RSTA: begin strobe.txStat = 1'b1; phaseD = PH_STAT_RD; end
            CMD_WSTA: phaseD = PH_STAT_WR;
            CMD_READ: begin isReadD = 1'b1; phaseD = PH_ADDR_HI; end
            CMD_WRIT: begin isReadD = 1'b0; phaseD = PH_ADDR_HI; end
            default:  phaseD = PH_SKIP;
          endcase
        end
        PH_ADDR_HI: begin
          strobe.addrHi = 1'b1;
          phaseD = PH_ADDR_LO;
        end
        PH_ADDR_LO: begin
          strobe.addrLo = 1'b1;
          strobe.txMem  = isReadQ;
          phaseD = PH_DATA;
        end
        PH_DATA: begin
          strobe.addrInc = 1'b1;
          if (isReadQ) begin
            strobe.txMem = 1'b1;
          end else begin
            strobe.memWr = 1'b1;
            wroteD = 1'b1;
          end
        end
        PH_STAT_RD: strobe.txStat = 1'b1;
        PH_STAT_WR: begin
          strobe.statWr = 1'b1;
          wroteD = 1'b1;
          phaseD = PH_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      isReadQ <= 1'b0;
      wroteQ  <= 1'b0;
    end else begin
      phaseQ  <= phaseD;
      isReadQ <= isReadD;
      wroteQ  <= wroteD;
    end
  end

  assign phase = phaseQ;

endmodule

// File: rtl/spi_byte_mem.sv
module spi_byte_mem
  import spi_byte_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic holdN,
  output logic so,
  output logic soEn
);

  ctrl_strobe_t strobe;
  phase_e       phase;
  logic         byteDone;
  logic [7:0]   rxByte;
  logic         csFall;
  logic         csRise;
  logic         selActive;
  logic         welQ;
  logic [2:0]   userBits;

  spi_byte_mem_dp #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sck      (sck),
    .si       (si),
    .holdN    (holdN),
    .strobe   (strobe),
    .so       (so),
    .soEn     (soEn),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .csFall   (csFall),
    .csRise   (csRise),
    .selActive(selActive),
    .welQ     (welQ),
    .userBits (userBits)
  );

  spi_byte_mem_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .byteDone(byteDone),
    .rxByte  (rxByte),
    .csFall  (csFall),
    .csRise  (csRise),
    .strobe  (strobe),
    .phase   (phase)
  );

endmodule

// File: rtl/spi_byte_mem_chk.sv
module spi_byte_mem_chk
  import spi_byte_mem_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       holdN,
  input logic       soEn,
  input logic       selActive,
  input logic       welQ,
  input logic [2:0] userBits,
  input phase_e     phase
);

  // R11
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |=> !soEn);

  // R11
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!holdN && !$past(holdN) && !$past(holdN, 2)) |=> !soEn);

  // R10
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selActive && $past(selActive) && phase == PH_CMD) |-> $past(phase) == PH_CMD);

  // R6
  status_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(userBits) |-> $past(welQ));

  // R2
  wel_set_in_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(welQ) |-> $past(selActive));

endmodule

bind spi_byte_mem spi_byte_mem_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .holdN    (holdN),
  .soEn     (soEn),
  .selActive(selActive),
  .welQ     (welQ),
  .userBits (userBits),
  .phase    (phase)
);

// File: tb/spi_byte_mem_tb_top.sv
module spi_byte_mem_tb_top;

  localparam int HP = 8;
  localparam int NVEC = 6;
  // {write address, read address, data}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h0010, 16'h0010, 8'h5A},
    {16'hE123, 16'h0123, 8'hC3},
    {16'h1FFF, 16'hFFFF, 8'h81},
    {16'h0000, 16'h2000, 8'h7E},
    {16'h0ABC, 16'h0ABC, 8'h00},
    {16'h1234, 16'hF234, 8'hFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic holdN = 1'b1;
  logic so, soEn;
  int   checks = 0;
  int   errors = 0;
  bit   curM3 = 1'b0;

  always #5 clk = ~clk;

  spi_byte_mem dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .holdN(holdN), .so(so), .soEn(soEn)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic selBegin(input bit m3);
    curM3 = m3;
    @(negedge clk) sck = m3;
    repeat (6) @(negedge clk);
    csN = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic selEnd();
    repeat (HP) @(negedge clk);
    if (!curM3) sck = 1'b0;
    repeat (HP) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xferBit(input logic b, output logic r);
    @(negedge clk) sck = 1'b0;
    si = b;
    repeat (HP) @(negedge clk);
    r = so;
    sck = 1'b1;
    repeat (HP - 1) @(negedge clk);
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) xferBit(tx[b], rx[b]);
  endtask

  task automatic cmdOnly(input logic [7:0] op, input bit m3);
    logic [7:0] d;
    selBegin(m3); xferByte(op, d); selEnd();
  endtask

  task automatic readStatus(output logic [7:0] st);
    logic [7:0] d;
    selBegin(1'b0); xferByte(8'h05, d); xferByte(8'h00, st); selEnd();
  endtask

  task automatic writeStatus(input logic [7:0] v);
    logic [7:0] d;
    selBegin(1'b1); xferByte(8'h01, d); xferByte(v, d); selEnd();
  endtask

  task automatic writeByte(input logic [15:0] a, input logic [7:0] v, input bit m3);
    logic [7:0] d;
    selBegin(m3);
    xferByte(8'h02, d); xferByte(a[15:8], d); xferByte(a[7:0], d); xferByte(v, d);
    selEnd();
  endtask

  task automatic readByte(input logic [15:0] a, input bit m3, output logic [7:0] v);
    logic [7:0] d;
    selBegin(m3);
    xferByte(8'h03, d); xferByte(a[15:8], d); xferByte(a[7:0], d); xferByte(8'h00, v);
    selEnd();
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] st, rd, d;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 / R11: reset state
    check1("R11 soEn idle", soEn, 1'b0);
    readStatus(st);
    check8("R1 status after reset", st, 8'h00);

    // table walk: R3, R4, R9, R12
    for (int i = 0; i < NVEC; i++) begin
      cmdOnly(8'h06, 1'b0);
      writeByte(VEC[i][39:24], VEC[i][7:0], i[0]);
      readByte(VEC[i][23:8], ~i[0], rd);
      check8($sformatf("R3 R4 R9 R12 vector %0d", i), rd, VEC[i][7:0]);
    end

    // R2: latch set/clear
    cmdOnly(8'h06, 1'b1);
    readStatus(st);
    check8("R2 latch set", st, 8'h02);
    cmdOnly(8'h04, 1'b0);
    readStatus(st);
    check8("R2 latch cleared", st, 8'h00);

    // R6: status write without latch
    writeStatus(8'hFF);
    readStatus(st);
    check8("R6 status write discarded", st, 8'h00);

    // R8 / R7: status write with latch
    cmdOnly(8'h06, 1'b0);
    writeStatus(8'hFF);
    readStatus(st);
    check8("R8 R7 status bits kept, latch cleared", st, 8'h8C);
    cmdOnly(8'h06, 1'b0);
    writeStatus(8'h00);
    readStatus(st);
    check8("R8 status cleared", st, 8'h00);

    // R6: array write without latch
    cmdOnly(8'h06, 1'b0);
    writeByte(16'h0200, 8'h11, 1'b0);
    writeByte(16'h0200, 8'h22, 1'b1);
    readByte(16'h0200, 1'b0, rd);
    check8("R6 array write discarded", rd, 8'h11);

    // R7: write clears latch; address-only write keeps it
    cmdOnly(8'h06, 1'b0);
    writeByte(16'h0201, 8'h33, 1'b0);
    readStatus(st);
    check8("R7 latch cleared after write", st, 8'h00);
    cmdOnly(8'h06, 1'b0);
    selBegin(1'b0);
    xferByte(8'h02, d); xferByte(8'h02, d); xferByte(8'h01, d);
    selEnd();
    readStatus(st);
    check8("R7 latch kept without data", st, 8'h02);
    cmdOnly(8'h04, 1'b0);

    // R5: burst with wrap
    cmdOnly(8'h06, 1'b0);
    selBegin(1'b1);
    xferByte(8'h02, d); xferByte(8'h1F, d); xferByte(8'hFE, d);
    xferByte(8'hA1, d); xferByte(8'hA2, d); xferByte(8'hA3, d); xferByte(8'hA4, d);
    selEnd();
    selBegin(1'b0);
    xferByte(8'h03, d); xferByte(8'h1F, d); xferByte(8'hFE, d);
    for (int k = 0; k < 4; k++) begin
      xferByte(8'h00, rd);
      check8($sformatf("R5 burst byte %0d", k), rd, 8'hA1 + k[7:0]);
    end
    selEnd();
    readByte(16'h0000, 1'b1, rd);
    check8("R5 wrapped address 0", rd, 8'hA3);

    // R10: second byte after a finished command is ignored
    cmdOnly(8'h06, 1'b0);
    selBegin(1'b0); xferByte(8'h04, d); xferByte(8'h06, d); selEnd();
    readStatus(st);
    check8("R10 byte after command ignored", st, 8'h00);
    cmdOnly(8'h06, 1'b0);
    selBegin(1'b1);
    xferByte(8'hAB, d); xferByte(8'h04, d); xferByte(8'h02, d);
    selEnd();
    readStatus(st);
    check8("R10 unknown command ignored", st, 8'h02);
    cmdOnly(8'h04, 1'b0);

    // R11: hold in mid read byte
    cmdOnly(8'h06, 1'b0);
    writeByte(16'h0300, 8'hA5, 1'b0);
    selBegin(1'b0);
    xferByte(8'h03, d); xferByte(8'h03, d); xferByte(8'h00, d);
    for (int b = 7; b >= 4; b--) xferBit(1'b0, rd[b]);
    @(negedge clk) sck = 1'b0;
    repeat (HP) @(negedge clk);
    holdN = 1'b0;
    repeat (6) @(negedge clk);
    check1("R11 soEn low in hold", soEn, 1'b0);
    for (int t = 0; t < 2; t++) begin
      sck = 1'b1; repeat (HP) @(negedge clk);
      sck = 1'b0; repeat (HP) @(negedge clk);
    end
    holdN = 1'b1;
    repeat (6) @(negedge clk);
    check1("R11 soEn back after hold", soEn, 1'b1);
    for (int b = 3; b >= 0; b--) xferBit(1'b0, rd[b]);
    selEnd();
    check8("R11 byte across hold", rd, 8'hA5);
    check1("R11 soEn low after deselect", soEn, 1'b0);

    finishRun();
  end

endmodule